// File: doc/BRIEF.md
# Eight-Mode Register with Shared Bidirectional Bus

This block is an 8-bit storage register that sits on a bidirectional data bus. A 3-bit mode input selects what the register does on each rising clock edge. It can keep its value, shift toward either end, count up or down, invert every bit, exchange its two 4-bit halves, or take in the value present on the bus. An active-high asynchronous reset clears it at once, without waiting for a clock edge.

The same bus carries the register's value out and the load value in. The register drives the bus while the output-enable input is high, except in load mode. In load mode, and whenever output enable is low, the bus is released to high impedance. The release decision is combinational, so another agent can place the load value on the bus in the same cycle that load mode is selected. The width is a parameter with a default of 8. It must be even, because of the half swap.

Top module: `mode_reg_bus`

## Requirements
- R1: While `arst` is 1 the register is 0x00. The clear takes effect at once, with no clock edge needed.
- R2: Mode 3'b000 leaves the register unchanged across clock edges.
- R3: Mode 3'b001 moves every bit one place toward bit 0. Bit 7 becomes 0 and the old bit 0 is lost.
- R4: Mode 3'b010 moves every bit one place toward bit 7. Bit 0 becomes 0 and the old bit 7 is lost.
- R5: Mode 3'b011 adds one modulo 256, so 0xFF becomes 0x00.
- R6: Mode 3'b100 subtracts one modulo 256, so 0x00 becomes 0xFF.
- R7: Mode 3'b101 inverts every bit.
- R8: Mode 3'b110 exchanges bits [7:4] with bits [3:0].
- R9: Mode 3'b111 captures the value present on `dbus` at the clock edge, whatever the value of `oe`.
- R10: When `oe` is 1 and the mode is not 3'b111, the register value appears on `dbus`. When `oe` is 0, the register does not drive `dbus`.
- R11: In mode 3'b111 the register releases `dbus` within the same cycle, with no clock edge needed, so a value driven on the bus by another agent is seen undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| mode | input | 3 | Operation select for the next edge |
| oe | input | 1 | Output enable toward the bus |
| dbus | inout | 8 | Shared data bus: register output and load source |

## Verification
Two things coincide in the same cycle: releasing the bus and loading from it. Both are triggered by mode 3'b111, and the case that matters is the one where `oe` stays high. The bench holds `oe` high and drives a value on the bus that is the bit complement of the register contents. Any leftover drive from the register would then corrupt every bit. The bench checks that the bus shows exactly its own value before the edge, and that the register holds that value after the edge. A second probe drives 0x00 with `oe` low, so that any drive the register should not apply becomes visible.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

   typedef enum logic [2:0] {
      OP_KEEP = 3'b000,
      OP_SHR  = 3'b001,
      OP_SHL  = 3'b010,
      OP_INC  = 3'b011,
      OP_DEC  = 3'b100,
      OP_INV  = 3'b101,
      OP_SWAP = 3'b110,
      OP_LOAD = 3'b111
   } op_e;

   localparam int unsigned OP_BITS = 3;

endpackage

// File: rtl/mrb_next.sv
module mrb_next
   import mrb_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  op_e              op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] nxt
);

   localparam int unsigned HALF = WIDTH / 2;

   logic [WIDTH-1:0] swapped;
   logic [WIDTH-1:0] shr_v;
   logic [WIDTH-1:0] shl_v;

   // Half exchange: each bit moves HALF positions, wrapping around.
   for (genvar i = 0; i < WIDTH; i++) begin : g_swap
      if (i < HALF) begin : g_lo
         assign swapped[i] = cur[i + HALF];
      end else begin : g_hi
         assign swapped[i] = cur[i - HALF];
      end
   end

   // Shifts: vacated end bit fills with 0.
   for (genvar i = 0; i < WIDTH; i++) begin : g_shift
      if (i == WIDTH - 1) begin : g_top
         assign shr_v[i] = 1'b0;
      end else begin : g_rmid
         assign shr_v[i] = cur[i + 1];
      end
      if (i == 0) begin : g_bot
         assign shl_v[i] = 1'b0;
      end else begin : g_lmid
         assign shl_v[i] = cur[i - 1];
      end
   end

   always_comb begin
      unique case (op)
         OP_KEEP: nxt = cur;
         OP_SHR:  nxt = shr_v;
         OP_SHL:  nxt = shl_v;
         OP_INC:  nxt = cur + WIDTH'(1);
         OP_DEC:  nxt = cur - WIDTH'(1);
         OP_INV:  nxt = ~cur;
         OP_SWAP: nxt = swapped;
         OP_LOAD: nxt = bus_in;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/mrb_store.sv
module mrb_store #(
   parameter int unsigned WIDTH     = 8,
   parameter logic [WIDTH-1:0] CLR_VAL = '0
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         q <= CLR_VAL;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/mrb_drive.sv
module mrb_drive
   import mrb_pkg::*;
(
   input  logic oe,
   input  op_e  op,
   output logic drv_en
);

   // Combinational: release happens in the same cycle load is chosen.
   assign drv_en = oe && (op != OP_LOAD);

endmodule

// File: rtl/mode_reg_bus.sv
module mode_reg_bus
   import mrb_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [2:0]       mode,
   input  logic             oe,
   inout  wire  [WIDTH-1:0] dbus
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 2) begin : g_chk_min
      $error("mode_reg_bus: WIDTH must be at least 2");
   end
   if ((WIDTH % 2) != 0) begin : g_chk_even
      $error("mode_reg_bus: WIDTH must be even for the half exchange");
   end

   op_e              op;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] bus_in;
   logic             drv_en;

   assign op     = op_e'(mode);
   assign bus_in = dbus;

   mrb_next #(.WIDTH(WIDTH)) u_next (
      .op     (op),
      .cur    (q),
      .bus_in (bus_in),
      .nxt    (nxt)
   );

   mrb_store #(.WIDTH(WIDTH), .CLR_VAL(ZERO)) u_store (
      .clk  (clk),
      .arst (arst),
      .d    (nxt),
      .q    (q)
   );

   mrb_drive u_drive (
      .oe     (oe),
      .op     (op),
      .drv_en (drv_en)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_tri
      assign dbus[i] = drv_en ? q[i] : 1'bz;
   end

   // Checks next to the register they guard.
   a_r1_clear: assert property (@(posedge clk) arst |-> (q == ZERO));
   a_r2_keep: assert property (@(posedge clk) disable iff (arst)
      (op == OP_KEEP) |=> (q == $past(q)));
   a_r3_shr: assert property (@(posedge clk) disable iff (arst)
      (op == OP_SHR) |=> (q == {1'b0, $past(q[WIDTH-1:1])}));
   a_r4_shl: assert property (@(posedge clk) disable iff (arst)
      (op == OP_SHL) |=> (q == {$past(q[WIDTH-2:0]), 1'b0}));
   a_r5_inc: assert property (@(posedge clk) disable iff (arst)
      (op == OP_INC) |=> (q == WIDTH'($past(q) + WIDTH'(1))));
   a_r6_dec: assert property (@(posedge clk) disable iff (arst)
      (op == OP_DEC) |=> (q == WIDTH'($past(q) - WIDTH'(1))));
   a_r7_inv: assert property (@(posedge clk) disable iff (arst)
      (op == OP_INV) |=> (q == ~$past(q)));
   a_r9_load: assert property (@(posedge clk) disable iff (arst)
      (op == OP_LOAD) |=> (q == $past(bus_in)));
   a_r10_drive: assert property (@(posedge clk) disable iff (arst)
      (oe && (op != OP_LOAD)) |-> (bus_in == q));
   a_r11_release: assert property (@(posedge clk) disable iff (arst)
      (op == OP_LOAD) |-> !drv_en);

endmodule

// File: tb/tb_mode_reg_bus.sv
module tb_mode_reg_bus;

   logic       clk = 1'b0;
   logic       arst;
   logic [2:0] mode;
   logic       oe;
   logic       tb_en;
   logic [7:0] tb_val;
   wire  [7:0] dbus;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   assign dbus = tb_en ? tb_val : 8'hzz;

   mode_reg_bus dut (
      .clk  (clk),
      .arst (arst),
      .mode (mode),
      .oe   (oe),
      .dbus (dbus)
   );

   typedef struct {
      string      req;
      logic [7:0] exp;
   } item_t;

   item_t sb_q[$];
   event  mon_ev;
   logic [7:0] model;

   // Monitor: pops the expected item and compares it with the bus.
   initial begin
      forever begin
         @(mon_ev);
         #1;
         if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (dbus !== it.exp) begin
               fails++;
               $display("FAIL %s: bus=%h expected=%h", it.req, dbus, it.exp);
            end
         end
      end
   end

   function automatic logic [7:0] ref_op(logic [2:0] m, logic [7:0] c, logic [7:0] b);
      case (m)
         3'b001:  return c >> 1;
         3'b010:  return c << 1;
         3'b011:  return c + 8'd1;
         3'b100:  return c - 8'd1;
         3'b101:  return c ^ 8'hFF;
         3'b110:  return {c[3:0], c[7:4]};
         3'b111:  return b;
         default: return c;
      endcase
   endfunction

   // Expect on the bus as currently set up; sample 1 ns later.
   task automatic expect_bus(string req, logic [7:0] exp);
      item_t it;
      it.req = req;
      it.exp = exp;
      sb_q.push_back(it);
      ->mon_ev;
      #1.5;
   endtask

   // Read register through the bus: mode keep, oe high.
   task automatic read_reg(string req);
      @(negedge clk);
      mode = 3'b000; oe = 1'b1; tb_en = 1'b0;
      expect_bus(req, model);
   endtask

   task automatic do_op(logic [2:0] m, logic o, logic [7:0] bv);
      @(negedge clk);
      mode = m; oe = o;
      tb_en  = (m == 3'b111);
      tb_val = bv;
      @(posedge clk);
      model = ref_op(m, model, bv);
   endtask

   initial begin
      arst = 1'b1; mode = 3'b000; oe = 1'b0; tb_en = 1'b0; tb_val = 8'h00;
      model = 8'h00;
      repeat (3) @(posedge clk);
      // R1: reset state
      read_reg("R1 reset value");
      @(negedge clk); arst = 1'b0;

      do_op(3'b111, 1'b0, 8'h96); read_reg("R9 load oe=0");
      do_op(3'b001, 1'b1, 8'h00); read_reg("R3 shift right 96");
      do_op(3'b010, 1'b1, 8'h00); read_reg("R4 shift left 4B");
      do_op(3'b111, 1'b1, 8'h81); do_op(3'b001, 1'b0, 8'h00); read_reg("R3 msb fill 0, lsb lost");
      do_op(3'b111, 1'b1, 8'h81); do_op(3'b010, 1'b0, 8'h00); read_reg("R4 lsb fill 0, msb lost");
      do_op(3'b111, 1'b1, 8'hFF); do_op(3'b011, 1'b1, 8'h00); read_reg("R5 wrap FF to 00");
      do_op(3'b100, 1'b1, 8'h00); read_reg("R6 wrap 00 to FF");
      do_op(3'b111, 1'b1, 8'h0F); do_op(3'b011, 1'b1, 8'h00); read_reg("R5 carry 0F to 10");
      do_op(3'b100, 1'b0, 8'h00); read_reg("R6 borrow 10 to 0F");
      do_op(3'b111, 1'b1, 8'h96); do_op(3'b101, 1'b1, 8'h00); read_reg("R7 invert 96");
      do_op(3'b111, 1'b1, 8'h3C); do_op(3'b110, 1'b1, 8'h00); read_reg("R8 swap 3C");
      do_op(3'b111, 1'b1, 8'h12); do_op(3'b110, 1'b0, 8'h00); read_reg("R8 swap 12");
      do_op(3'b111, 1'b1, 8'h5A);
      for (int k = 0; k < 3; k++) do_op(3'b000, k[0], 8'h00);
      read_reg("R2 keep over 3 edges");

      // R10: oe low releases bus; bench drives 00 so any drive shows.
      @(negedge clk);
      mode = 3'b000; oe = 1'b0; tb_en = 1'b1; tb_val = 8'h00;
      expect_bus("R10 oe low no drive", 8'h00);
      @(negedge clk);
      mode = 3'b011; oe = 1'b1; tb_en = 1'b0;
      expect_bus("R10 drive in count mode", model);
      @(posedge clk); model = ref_op(3'b011, model, 8'h00);

      // R11 and R9: load with oe high, bus carries complement of register.
      do_op(3'b111, 1'b1, 8'hF0);
      @(negedge clk);
      mode = 3'b111; oe = 1'b1; tb_en = 1'b1; tb_val = 8'h0F;
      expect_bus("R11 release same cycle", 8'h0F);
      @(posedge clk); model = 8'h0F;
      read_reg("R9 load with oe high");

      // R1: asynchronous clear mid-cycle, checked before next edge.
      do_op(3'b111, 1'b1, 8'hA5);
      @(negedge clk);
      mode = 3'b000; oe = 1'b1; tb_en = 1'b0;
      arst = 1'b1; model = 8'h00;
      expect_bus("R1 async clear no edge", 8'h00);
      @(negedge clk); arst = 1'b0;
      do_op(3'b011, 1'b1, 8'h00); read_reg("R1 count after clear");

      repeat (2) @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule